// File: doc/BRIEF.md
# Pipelined Sine/Cosine Rotation Engine with Preset Front Iterations

This block turns a phase word into a sine and a cosine by running eight unrolled rotation iterations of the coordinate rotation algorithm. Every iteration shifts and adds. Only the iterations from the fourth onward do this in hardware. The starting vector is fixed: x holds a gain-compensating constant and y is zero. Because of that, the coordinates after the first three iterations can only take eight possible pairs. These pairs are worked out at elaboration and chosen by a multiplexer driven by the first three rotation directions. The angle path still computes those three directions with ordinary adders.

The input phase is folded into the right half plane before the iterations start, and the result signs are corrected at the end. Two register stages divide the datapath. The first sits after the fourth iteration and the second after the seventh. The block takes a new phase on every clock and returns each result two clocks later. With every result it also gives the angle left over after the last iteration.

Top module: `sc_cordic_sincos`

## Requirements
- R1: While the reset input is low, and in the first cycle after any cycle with reset low, out_vld is 0. A reset asserted while phases are in flight discards them, and no result appears for them.
- R2: A phase accepted with in_vld high in cycle c produces out_vld high in cycle c+2. Back-to-back phases produce back-to-back results.
- R3: The phase is 8 bits, with 256 counts to a full turn (0x20 is 45 degrees, 0x40 is 90 degrees). A phase whose two top bits differ has 128 added to it before iteration, and both outputs are then negated.
- R4: The first three iterations use no coordinate adders. The x/y pair that enters the fourth iteration is one of eight constant pairs. Each pair is formed from the starting x of 155 by the shift-add rule, and the pair is picked by the three direction bits.
- R5: The result matches the reference algorithm bit for bit. The reference starts with x=155, y=0 and z = (folded phase as signed) * 256, where a full turn is 65536. Each iteration i = 0..7 sets d = +1 if z >= 0 and -1 otherwise. It then applies x -= d*(y>>>i) and y += d*(x>>>i), both using the old values, and z -= d*A[i], with A = 8192, 4836, 2555, 1297, 651, 326, 163, 81.
- R6: out_cos equals the final x arithmetically shifted right by one, and out_sin is the same for the final y. Both are 9-bit signed, and the negation from R3 is applied after that shift. Unity is 128.
- R7: out_eps is the final z as a 16-bit signed value, and its magnitude never exceeds 162.
- R8: out_sin and out_cos are within 6 counts of 128*sin and 128*cos of the phase. The squared magnitude lies between 112^2 and 136^2.
- R9: A cycle with in_vld low produces no result: out_vld stays low two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Phase word valid this cycle |
| in_phase | input | 8 | Phase, 256 counts per turn |
| out_vld | output | 1 | Result valid this cycle |
| out_sin | output | 9 | Sine, signed, unity 128 |
| out_cos | output | 9 | Cosine, signed, unity 128 |
| out_eps | output | 16 | Residual angle after the last iteration, signed, 65536 per turn |

## Verification
Some properties are checked on every clock: the valid bit keeps its fixed two-cycle delay and raises no result without an input, reset clears the output valid, the residual stays inside its bound, and every valid result lies on a ring around unit magnitude. Three things can only be shown by the scenarios. One is bit-exact agreement with the shift-add rule for each phase, which covers all eight preset pairs and both folded quadrants. The others are the closeness to the true sine and cosine, and the discarding of phases that are in flight when reset arrives.

// File: rtl/sc_cordic_pkg.sv
package sc_cordic_pkg;

   // angle table resolution: one full turn is 2**ATAN_REF_W counts
   localparam int ATAN_REF_W = 16;

   // arctangent of 2**-i, in units of a full turn scaled to 2**aw counts
   function automatic int atan_step(int i, int aw);
      int t;
      case (i)
         0: t = 8192;
         1: t = 4836;
         2: t = 2555;
         3: t = 1297;
         4: t = 651;
         5: t = 326;
         6: t = 163;
         7: t = 81;
         default: t = 0;
      endcase
      return t >>> (ATAN_REF_W - aw);
   endfunction

   // starting x: unity of 2**(xw-2) divided by the eight-iteration gain
   function automatic int gain_inverse(int xw);
      real unity;
      unity = 2.0 ** (xw - 2);
      return int'(unity / 1.6467602581);
   endfunction

   // coordinates after the first three iterations for direction bits sel
   // (bit i set means a positive rotation in iteration i)
   function automatic logic [63:0] preset_pair(int x0, int sel);
      int x, y, xn, yn;
      x = x0;
      y = 0;
      for (int i = 0; i < 3; i++) begin
         if (((sel >> i) & 1) == 1) begin
            xn = x - (y >>> i);
            yn = y + (x >>> i);
         end else begin
            xn = x + (y >>> i);
            yn = y - (x >>> i);
         end
         x = xn;
         y = yn;
      end
      return {x, y};
   endfunction

endpackage

// File: rtl/sc_cordic_stage.sv
module sc_cordic_stage #(
   parameter int XW    = 10,
   parameter int AW    = 16,
   parameter int SHIFT = 3,
   parameter int STEP  = 1297
) (
   input  logic signed [XW-1:0] x_i,
   input  logic signed [XW-1:0] y_i,
   input  logic signed [AW-1:0] z_i,
   output logic signed [XW-1:0] x_o,
   output logic signed [XW-1:0] y_o,
   output logic signed [AW-1:0] z_o
);

   localparam logic signed [AW-1:0] ANGLE = AW'(STEP);

   logic                 ccw;
   logic signed [XW-1:0] xs;
   logic signed [XW-1:0] ys;

   assign ccw = ~z_i[AW-1];
   assign xs  = x_i >>> SHIFT;
   assign ys  = y_i >>> SHIFT;

   always_comb begin
      if (ccw) begin
         x_o = x_i - ys;
         y_o = y_i + xs;
         z_o = z_i - ANGLE;
      end else begin
         x_o = x_i + ys;
         y_o = y_i - xs;
         z_o = z_i + ANGLE;
      end
   end

endmodule

// File: rtl/sc_cordic_preset.sv
module sc_cordic_preset #(
   parameter int XW = 10,
   parameter int X0 = 155
) (
   input  logic [2:0]           dir,
   output logic signed [XW-1:0] x_o,
   output logic signed [XW-1:0] y_o
);

   localparam int NPAIR = 8;

   logic signed [XW-1:0] tab_x [NPAIR];
   logic signed [XW-1:0] tab_y [NPAIR];

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      localparam logic [63:0] PAIR = sc_cordic_pkg::preset_pair(X0, k);
      assign tab_x[k] = PAIR[32 +: XW];
      assign tab_y[k] = PAIR[0 +: XW];
   end

   assign x_o = tab_x[dir];
   assign y_o = tab_y[dir];

endmodule

// File: rtl/sc_cordic_sincos.sv
module sc_cordic_sincos #(
   parameter int PW = 8,
   parameter int AW = 16,
   parameter int XW = 10,
   parameter int OW = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vld,
   input  logic [PW-1:0]        in_phase,
   output logic                 out_vld,
   output logic signed [OW-1:0] out_sin,
   output logic signed [OW-1:0] out_cos,
   output logic signed [AW-1:0] out_eps
);

   localparam int NPRE = 3;
   localparam int NMID = 3;
   localparam int X0   = sc_cordic_pkg::gain_inverse(XW);

   if (XW < 10 || OW >= XW || AW <= PW || AW > sc_cordic_pkg::ATAN_REF_W || PW < 3) begin : g_bad_cfg
      $error("sc_cordic_sincos: unsupported width combination");
   end

   // ---------------- segment A: fold, angle path, preset, iteration 3
   logic                 fold_a;
   logic [PW-1:0]        ph_f;
   logic signed [AW-1:0] za [NPRE+1];
   logic [NPRE-1:0]      dir_a;
   logic signed [XW-1:0] x3, y3, x4, y4;
   logic signed [AW-1:0] z4;

   assign fold_a = in_phase[PW-1] ^ in_phase[PW-2];
   // adding half a turn when the top two bits differ copies bit PW-2 upward
   assign ph_f   = {in_phase[PW-2], in_phase[PW-2:0]};
   assign za[0]  = {ph_f, {(AW-PW){1'b0}}};

   for (genvar i = 0; i < NPRE; i++) begin : g_pre_angle
      localparam logic signed [AW-1:0] ANG = AW'(sc_cordic_pkg::atan_step(i, AW));
      assign dir_a[i]  = ~za[i][AW-1];
      assign za[i+1]   = dir_a[i] ? za[i] - ANG : za[i] + ANG;
   end

   sc_cordic_preset #(.XW(XW), .X0(X0)) preset_i (
      .dir (dir_a),
      .x_o (x3),
      .y_o (y3)
   );

   sc_cordic_stage #(.XW(XW), .AW(AW), .SHIFT(NPRE),
                     .STEP(sc_cordic_pkg::atan_step(NPRE, AW))) stage3_i (
      .x_i (x3), .y_i (y3), .z_i (za[NPRE]),
      .x_o (x4), .y_o (y4), .z_o (z4)
   );

   // ---------------- register after iteration 4
   logic                 vld1, fold1;
   logic signed [XW-1:0] x1r, y1r;
   logic signed [AW-1:0] z1r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld1 <= 1'b0;
      else        vld1 <= in_vld;
   end

   always_ff @(posedge clk) begin
      x1r   <= x4;
      y1r   <= y4;
      z1r   <= z4;
      fold1 <= fold_a;
   end

   // ---------------- segment B: iterations 5 to 7
   logic signed [XW-1:0] xb [NMID+1];
   logic signed [XW-1:0] yb [NMID+1];
   logic signed [AW-1:0] zb [NMID+1];

   assign xb[0] = x1r;
   assign yb[0] = y1r;
   assign zb[0] = z1r;

   for (genvar k = 0; k < NMID; k++) begin : g_mid
      sc_cordic_stage #(.XW(XW), .AW(AW), .SHIFT(NPRE+1+k),
                        .STEP(sc_cordic_pkg::atan_step(NPRE+1+k, AW))) stage_i (
         .x_i (xb[k]),   .y_i (yb[k]),   .z_i (zb[k]),
         .x_o (xb[k+1]), .y_o (yb[k+1]), .z_o (zb[k+1])
      );
   end

   // ---------------- register after iteration 7
   logic                 vld2, fold2;
   logic signed [XW-1:0] x2r, y2r;
   logic signed [AW-1:0] z2r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld2 <= 1'b0;
      else        vld2 <= vld1;
   end

   always_ff @(posedge clk) begin
      x2r   <= xb[NMID];
      y2r   <= yb[NMID];
      z2r   <= zb[NMID];
      fold2 <= fold1;
   end

   // ---------------- last iteration, truncation, sign correction
   localparam int LAST = NPRE + 1 + NMID;

   logic signed [XW-1:0] xf, yf;
   logic signed [AW-1:0] zf;
   logic signed [OW-1:0] cos_t, sin_t;

   sc_cordic_stage #(.XW(XW), .AW(AW), .SHIFT(LAST),
                     .STEP(sc_cordic_pkg::atan_step(LAST, AW))) stage_last_i (
      .x_i (x2r), .y_i (y2r), .z_i (z2r),
      .x_o (xf),  .y_o (yf),  .z_o (zf)
   );

   assign cos_t   = xf[XW-1 -: OW];
   assign sin_t   = yf[XW-1 -: OW];
   assign out_cos = fold2 ? -cos_t : cos_t;
   assign out_sin = fold2 ? -sin_t : sin_t;
   assign out_eps = zf;
   assign out_vld = vld2;

endmodule

// File: rtl/sc_cordic_chk.sv
module sc_cordic_chk #(
   parameter int AW = 16,
   parameter int OW = 9
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_vld,
   input logic                 out_vld,
   input logic signed [OW-1:0] out_sin,
   input logic signed [OW-1:0] out_cos,
   input logic signed [AW-1:0] out_eps
);

   localparam int UNITY   = 2 ** (OW - 2);
   localparam int EPS_MAX = 2 * sc_cordic_pkg::atan_step(7, AW);
   localparam int MAG_LO  = (UNITY * 7 / 8) * (UNITY * 7 / 8);
   localparam int MAG_HI  = (UNITY * 17 / 16) * (UNITY * 17 / 16);

   int s_i, c_i, e_i, mag2;

   always_comb begin
      s_i  = int'(out_sin);
      c_i  = int'(out_cos);
      e_i  = int'(out_eps);
      mag2 = s_i * s_i + c_i * c_i;
   end

   p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> !out_vld)
      else $error("out_vld high right after reset");

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_vld, 2) |-> out_vld)
      else $error("accepted phase produced no result two cycles later");

   p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(in_vld, 2))
      else $error("result without a phase two cycles earlier");

   p_eps_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (e_i <= EPS_MAX && e_i >= -EPS_MAX))
      else $error("residual angle out of bound");

   p_magnitude_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (mag2 >= MAG_LO && mag2 <= MAG_HI))
      else $error("result magnitude off the unit ring");

endmodule

bind sc_cordic_sincos sc_cordic_chk #(.AW(AW), .OW(OW)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .out_vld (out_vld),
   .out_sin (out_sin),
   .out_cos (out_cos),
   .out_eps (out_eps)
);

// File: tb/sc_cordic_sincos_tb_top.sv
module sc_cordic_sincos_tb_top;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      int phase;
      int fold;
      int sin_v;
      int cos_v;
      int eps_v;
      int cyc;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_vld = 1'b0;
   logic [7:0]        in_phase = 8'h00;
   logic              out_vld;
   logic signed [8:0] out_sin, out_cos;
   logic signed [15:0] out_eps;

   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sc_cordic_sincos dut_i (
      .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .in_phase (in_phase),
      .out_vld (out_vld), .out_sin (out_sin), .out_cos (out_cos), .out_eps (out_eps)
   );

   task automatic chk(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
      end
   endtask

   task automatic chk_near(string tag, int got, int exp, int tol);
      checks++;
      if (got > exp + tol || got < exp - tol) begin
         errors++;
         $display("FAIL %s got=%0d exp=%0d (tol %0d)", tag, got, exp, tol);
      end
   endtask

   // reference shift-add model written from R3, R5, R6
   function automatic exp_t ref_model(int ph);
      exp_t e;
      int at[8] = '{8192, 4836, 2555, 1297, 651, 326, 163, 81};
      int f, z, x, y, xn, yn;
      e.phase = ph;
      e.fold  = ((ph >> 7) ^ (ph >> 6)) & 1;
      f = (e.fold == 1) ? ((ph + 128) % 256) : ph;
      z = ((f >= 128) ? f - 256 : f) * 256;
      x = 155;
      y = 0;
      for (int i = 0; i < 8; i++) begin
         if (z >= 0) begin
            xn = x - (y >>> i); yn = y + (x >>> i); z = z - at[i];
         end else begin
            xn = x + (y >>> i); yn = y - (x >>> i); z = z + at[i];
         end
         x = xn;
         y = yn;
      end
      e.cos_v = x >>> 1;
      e.sin_v = y >>> 1;
      if (e.fold == 1) begin
         e.cos_v = -e.cos_v;
         e.sin_v = -e.sin_v;
      end
      e.eps_v = z;
      e.cyc   = 0;
      return e;
   endfunction

   task automatic drive(int ph);
      exp_t e;
      @(negedge clk);
      in_vld   = 1'b1;
      in_phase = 8'(ph);
      e = ref_model(ph);
      e.cyc = cyc;
      q.push_back(e);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
   endtask

   task automatic expect_quiet(string tag, int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk(tag, int'(out_vld), 0);
      end
   endtask

   // monitor: pop and compare every result
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         if (q.size() == 0) begin
            chk("R9 result without accepted phase", 1, 0);
         end else begin
            exp_t e;
            real  ang;
            string tg;
            e   = q.pop_front();
            ang = e.phase * 2.0 * 3.14159265358979 / 256.0;
            tg  = (e.fold == 1) ? "R3 R4 R5 R6" : "R4 R5 R6";
            chk("R2 latency", cyc - e.cyc, 2);
            chk({tg, " sin"}, int'(out_sin), e.sin_v);
            chk({tg, " cos"}, int'(out_cos), e.cos_v);
            chk("R5 R7 eps", int'(out_eps), e.eps_v);
            chk("R7 eps bound", int'(int'(out_eps) <= 162 && int'(out_eps) >= -162), 1);
            chk_near("R8 sin accuracy", int'(out_sin), int'(128.0 * $sin(ang)), 6);
            chk_near("R8 cos accuracy", int'(out_cos), int'(128.0 * $cos(ang)), 6);
         end
      end
   end

   initial begin
      int dir_list[14] = '{8'h00, 8'h20, 8'h15, 8'h40, 8'h3F, 8'h41, 8'h80,
                           8'h7F, 8'hC0, 8'hBF, 8'hFF, 8'hE0, 8'h60, 8'hA0};
      // R1: reset state
      expect_quiet("R1 out_vld in reset", 3);
      @(negedge clk);
      rst_n = 1'b1;
      expect_quiet("R1 out_vld after reset", 3);

      // directed phases, back to back (R2, R3, R8)
      foreach (dir_list[k]) drive(dir_list[k]);
      idle(4);

      // full sweep, one phase per clock: all preset pairs, all quadrants
      for (int p = 0; p < 256; p++) drive(p);
      idle(4);

      // R9: bubbles in the input stream
      for (int p = 0; p < 60; p++) begin
         if (p % 3 == 1) idle(1);
         else            drive((p * 37) % 256);
      end
      idle(4);
      chk("R9 queue drained after bubbles", q.size(), 0);

      // R1: reset while a phase is in flight
      drive(8'h30);
      @(negedge clk);
      in_vld = 1'b0;
      rst_n  = 1'b0;
      q.delete();
      expect_quiet("R1 in-flight phase dropped in reset", 3);
      @(negedge clk);
      rst_n = 1'b1;
      expect_quiet("R1 in-flight phase dropped after reset", 3);

      // pipeline works again after the mid-stream reset
      drive(8'h20);
      drive(8'hC0);
      idle(4);
      chk("R2 all results delivered", q.size(), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule